// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block gathers interrupt events from a USB controller core and presents them to a processor as a single interrupt line. Events fall into two groups. The endpoint group carries one bit per transmit endpoint (endpoint 0 and fifteen more) and one bit per receive endpoint (fifteen). The core group carries a nine-bit field of core events. One of those core events reports a change of the drive-VBUS signal. Each group has a latched source register, a mask register and a read-only masked view. Software can write either register whole, or change single bits through write-one-to-set and write-one-to-clear aliases. The set alias lets software raise an event artificially.

The interrupt line rises when any unmasked event is pending and the line is armed. Once it has fired, it disarms. It cannot rise again until software writes the end-of-interrupt register, even if events are still pending. A control register holds a self-clearing soft-reset bit, which empties every source and mask register. A status register reports the drive-VBUS level. A fixed nonzero revision word lets software detect that the block is present and clocked.

The register port is a simple command interface. One command is accepted per cycle and there is no back-pressure: `cmd_valid` is never refused. Each read returns data one cycle later, flagged by `rd_valid`. Addresses are byte addresses of 32-bit words, and a command whose low two address bits are nonzero decodes to nothing.

Top module: `usb_irq_wrap`

## Requirements
- R1: A read of offset 0x00 returns the nonzero constant `REVISION`.
- R2: A high bit on `ep_evt_i` or `core_evt_i`, sampled on a clock edge, sets the matching source bit. Endpoint source bit 16 always reads 0. Core event input bit k maps to core source bit 16+k. All other core source bits always read 0.
- R3: The source registers are at 0x20 (endpoint) and 0x40 (core). A write to one of them loads the written value. A write to 0x24 or 0x44 sets every source bit written as 1. A write to 0x28 or 0x48 clears every source bit written as 1.
- R4: When a hardware event and a clear-alias write hit the same source bit in the same cycle, the bit ends up set.
- R5: The mask registers are at 0x2C (endpoint) and 0x4C (core). A write there loads the mask. Offsets 0x30 and 0x50 set mask bits written as 1, and 0x34 and 0x54 clear them.
- R6: Offsets 0x38 (endpoint) and 0x58 (core) read as the source register AND the mask register.
- R7: While armed, `irq_o` rises on the clock edge after any masked bit becomes nonzero. It stays high while masked bits remain, and falls on the edge after they are all zero.
- R8: Once `irq_o` has risen, the line is disarmed and does not rise again until a write of any value to offset 0x60. That write drops `irq_o` for at least one cycle and re-arms the line. Armed is the reset state.
- R9: Writing 1 to bit 0 of the control register (0x04) sets that bit for exactly the next cycle. In that cycle it reads as 1, and every source and mask register is cleared at its closing edge. Events sampled on that edge are dropped.
- R10: Bit 0 of the status register (0x08) returns the level of `drvvbus_i` in the read cycle. The upper bits read 0.
- R11: Reads of reserved or unmapped offsets (for example 0x10, 0x5C, 0x7C) return 0. The alias offsets and 0x60 also read 0. Writes to reserved offsets change nothing.
- R12: Every read command produces `rd_valid` high exactly one cycle later. No other cycle has `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Register command present (always accepted) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address of the register |
| cmd_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read command |
| rd_data | output | 32 | Read data |
| ep_evt_i | input | 32 | Endpoint event strobes (bit 16 unused) |
| core_evt_i | input | 9 | Core event strobes; bit 8 is the drive-VBUS change |
| drvvbus_i | input | 1 | Current drive-VBUS level |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The main collision is a hardware event and a software acknowledge on the same source bit in one cycle. A second collision is an end-of-interrupt write that lands while masked events are still pending. Directed sequences force both of these. Sparse random event strobes are then mixed with random clear, set and end-of-interrupt writes so that they overlap often. A bench-side register model, built from the requirements, predicts every read word and the interrupt level cycle by cycle. It shows whether an acknowledged event survived its collision and whether the line re-fires only after re-arming.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int DATA_W   = 32;
  localparam int CORE_W   = 9;
  localparam int CORE_LSB = 16;
  localparam logic [DATA_W-1:0] EP_VALID = 32'hFFFE_FFFF;

  typedef enum logic [4:0] {
    W_REV      = 5'd0,
    W_CTRL     = 5'd1,
    W_STAT     = 5'd2,
    W_EP_SRC   = 5'd8,
    W_EP_SET   = 5'd9,
    W_EP_CLR   = 5'd10,
    W_EP_MSK   = 5'd11,
    W_EP_MSET  = 5'd12,
    W_EP_MCLR  = 5'd13,
    W_EP_VIEW  = 5'd14,
    W_CO_SRC   = 5'd16,
    W_CO_SET   = 5'd17,
    W_CO_CLR   = 5'd18,
    W_CO_MSK   = 5'd19,
    W_CO_MSET  = 5'd20,
    W_CO_MCLR  = 5'd21,
    W_CO_VIEW  = 5'd22,
    W_EOI      = 5'd24
  } word_e;
endpackage

// File: rtl/usbirq_group.sv
module usbirq_group #(
  parameter int W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic [W-1:0] evt_i,
  input  logic         wr_src_i,
  input  logic         wr_set_i,
  input  logic         wr_clr_i,
  input  logic         wr_msk_i,
  input  logic         wr_mset_i,
  input  logic         wr_mclr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] msk_o,
  output logic [W-1:0] view_o,
  output logic         pend_o
);
  logic [W-1:0] src_q, msk_q, src_d, msk_d, sw_src, sw_msk;

  always_comb begin
    sw_src = src_q;
    if (wr_src_i)      sw_src = wdata_i;
    else if (wr_set_i) sw_src = src_q | wdata_i;
    else if (wr_clr_i) sw_src = src_q & ~wdata_i;
    // hardware events are ORed after the clear so they are never lost
    src_d = (sw_src | evt_i) & VALID;

    sw_msk = msk_q;
    if (wr_msk_i)       sw_msk = wdata_i;
    else if (wr_mset_i) sw_msk = msk_q | wdata_i;
    else if (wr_mclr_i) sw_msk = msk_q & ~wdata_i;
    msk_d = sw_msk & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      msk_q <= '0;
    end else if (srst_i) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      src_q <= src_d;
      msk_q <= msk_d;
    end
  end

  assign src_o  = src_q;
  assign msk_o  = msk_q;
  assign view_o = src_q & msk_q;
  assign pend_o = |view_o;

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_i |=> ((src_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q | msk_q) & ~VALID) == '0);
  p_srst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (src_q == '0 && msk_q == '0));
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set_i && !srst_i) |=> ((src_q & $past(wdata_i & VALID)) == $past(wdata_i & VALID)));
endmodule

// File: rtl/usbirq_arm.sv
module usbirq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q, irq_q, fire;

  assign fire = armed_q & pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (eoi_i) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      irq_q   <= irq_q & pend_i;
    end
  end

  assign irq_o = irq_q;

  p_rise_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(armed_q) && !$past(eoi_i)));
  p_hold_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(pend_i));
  p_eoi_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i |=> (!irq_q && armed_q));
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap #(
  parameter int ADDR_W = 7,
  parameter logic [31:0] REVISION = 32'h4EA2_0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [31:0]       ep_evt_i,
  input  logic [8:0]        core_evt_i,
  input  logic              drvvbus_i,
  output logic              irq_o
);
  import usbirq_pkg::*;

  localparam int WORD_W = ADDR_W - 2;

  logic              aligned, wr, rd;
  logic [WORD_W-1:0] word;
  logic              srst_q;
  logic [DATA_W-1:0] ep_src, ep_msk, ep_view;
  logic [CORE_W-1:0] co_src, co_msk, co_view;
  logic              ep_pend, co_pend;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q, rd_mux;

  assign aligned = (cmd_addr[1:0] == 2'b00);
  assign word    = cmd_addr[ADDR_W-1:2];
  assign wr      = cmd_valid & cmd_write & aligned;
  assign rd      = cmd_valid & ~cmd_write;

  function automatic logic hit(input word_e w);
    return word == WORD_W'(w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= wr & hit(W_CTRL) & cmd_wdata[0];
  end

  usbirq_group #(.W(DATA_W), .VALID(EP_VALID)) u_ep (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_q), .evt_i(ep_evt_i),
    .wr_src_i(wr & hit(W_EP_SRC)), .wr_set_i(wr & hit(W_EP_SET)),
    .wr_clr_i(wr & hit(W_EP_CLR)), .wr_msk_i(wr & hit(W_EP_MSK)),
    .wr_mset_i(wr & hit(W_EP_MSET)), .wr_mclr_i(wr & hit(W_EP_MCLR)),
    .wdata_i(cmd_wdata), .src_o(ep_src), .msk_o(ep_msk),
    .view_o(ep_view), .pend_o(ep_pend)
  );

  usbirq_group #(.W(CORE_W), .VALID({CORE_W{1'b1}})) u_core (
    .clk(clk), .rst_n(rst_n), .srst_i(srst_q), .evt_i(core_evt_i),
    .wr_src_i(wr & hit(W_CO_SRC)), .wr_set_i(wr & hit(W_CO_SET)),
    .wr_clr_i(wr & hit(W_CO_CLR)), .wr_msk_i(wr & hit(W_CO_MSK)),
    .wr_mset_i(wr & hit(W_CO_MSET)), .wr_mclr_i(wr & hit(W_CO_MCLR)),
    .wdata_i(cmd_wdata[CORE_LSB +: CORE_W]), .src_o(co_src), .msk_o(co_msk),
    .view_o(co_view), .pend_o(co_pend)
  );

  usbirq_arm u_arm (
    .clk(clk), .rst_n(rst_n), .pend_i(ep_pend | co_pend),
    .eoi_i(wr & hit(W_EOI)), .irq_o(irq_o)
  );

  function automatic logic [DATA_W-1:0] core_word(input logic [CORE_W-1:0] f);
    return DATA_W'(f) << CORE_LSB;
  endfunction

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if      (hit(W_REV))     rd_mux = REVISION;
      else if (hit(W_CTRL))    rd_mux = DATA_W'(srst_q);
      else if (hit(W_STAT))    rd_mux = DATA_W'(drvvbus_i);
      else if (hit(W_EP_SRC))  rd_mux = ep_src;
      else if (hit(W_EP_MSK))  rd_mux = ep_msk;
      else if (hit(W_EP_VIEW)) rd_mux = ep_view;
      else if (hit(W_CO_SRC))  rd_mux = core_word(co_src);
      else if (hit(W_CO_MSK))  rd_mux = core_word(co_msk);
      else if (hit(W_CO_VIEW)) rd_mux = core_word(co_view);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd;
      if (rd) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  p_no_spurious_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rd_valid);
  p_revision_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && cmd_addr == ADDR_W'(0)) |=> (rd_data == REVISION && rd_data != '0));
  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && cmd_addr == ADDR_W'(8)) |=> (rd_data == {31'b0, $past(drvvbus_i)}));
  p_srst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q || $past(wr && hit(W_CTRL) && cmd_wdata[0]));
endmodule

// File: tb/tb_usb_irq_wrap.sv
module tb_usb_irq_wrap;
  localparam logic [31:0] REV = 32'h4EA2_0103;
  localparam logic [31:0] EPV = 32'hFFFE_FFFF;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [6:0]  cmd_addr = 0;
  logic [31:0] cmd_wdata = 0, ep_evt_i = 0;
  logic [8:0]  core_evt_i = 0;
  logic        drvvbus_i = 0;
  logic        rd_valid, irq_o;
  logic [31:0] rd_data;

  usb_irq_wrap #(.ADDR_W(7), .REVISION(REV)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ep_evt_i(ep_evt_i), .core_evt_i(core_evt_i),
    .drvvbus_i(drvvbus_i), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // requirement-level model of the register file
  logic [31:0] m_eps, m_epm;
  logic [8:0]  m_cs, m_cm;
  logic        m_arm, m_irq, m_srst, e_rv;
  logic [31:0] e_rd;
  int          e_word;

  function automatic logic [31:0] mread(input int w);
    case (w)
      0:  return REV;
      1:  return {31'b0, m_srst};
      2:  return {31'b0, drvvbus_i};
      8:  return m_eps;
      11: return m_epm;
      14: return m_eps & m_epm;
      16: return {7'b0, m_cs, 16'b0};
      19: return {7'b0, m_cm, 16'b0};
      22: return {7'b0, m_cs & m_cm, 16'b0};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string tag(input int w);
    case (w)
      0: return "R1"; 1: return "R9"; 2: return "R10";
      8, 16: return "R2 R3 R4"; 11, 19: return "R5"; 14, 22: return "R6";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_eps = 0; m_epm = 0; m_cs = 0; m_cm = 0;
      m_arm = 1; m_irq = 0; m_srst = 0; e_rv = 0; e_rd = 0;
    end else begin
      int w;
      logic wr, pend;
      logic [31:0] d;
      logic [8:0] cd;
      w  = int'(cmd_addr[6:2]);
      wr = cmd_valid && cmd_write;
      d  = cmd_wdata;
      cd = d[24:16];
      e_rv = cmd_valid && !cmd_write;
      if (e_rv) begin e_rd = mread(w); e_word = w; end
      pend = |(m_eps & m_epm) || |(m_cs & m_cm);
      if (wr && w == 24) begin m_arm = 1; m_irq = 0; end
      else if (m_arm && pend) begin m_arm = 0; m_irq = 1; end
      else m_irq = m_irq && pend;
      if (m_srst) begin
        m_eps = 0; m_epm = 0; m_cs = 0; m_cm = 0;
      end else begin
        if (wr && w == 8) m_eps = d; else if (wr && w == 9) m_eps |= d;
        else if (wr && w == 10) m_eps &= ~d;
        m_eps = (m_eps | ep_evt_i) & EPV;
        if (wr && w == 11) m_epm = d; else if (wr && w == 12) m_epm |= d;
        else if (wr && w == 13) m_epm &= ~d;
        m_epm = m_epm & EPV;
        if (wr && w == 16) m_cs = cd; else if (wr && w == 17) m_cs |= cd;
        else if (wr && w == 18) m_cs &= ~cd;
        m_cs = m_cs | core_evt_i;
        if (wr && w == 19) m_cm = cd; else if (wr && w == 20) m_cm |= cd;
        else if (wr && w == 21) m_cm &= ~cd;
      end
      m_srst = wr && w == 1 && d[0];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R12 rd_valid", {31'b0, rd_valid}, {31'b0, e_rv});
    if (e_rv) check(tag(e_word), rd_data, e_rd);
    check("R7 R8 irq", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic step(input logic v, input logic wrt, input logic [6:0] a,
                      input logic [31:0] d, input logic [31:0] ep, input logic [8:0] co);
    @(negedge clk);
    compare();
    cmd_valid = v; cmd_write = wrt; cmd_addr = a; cmd_wdata = d;
    ep_evt_i = ep; core_evt_i = co;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0);
  endtask
  task automatic rd_reg(input logic [6:0] a);
    step(1, 0, a, 0, 0, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // reset state and revision (R1)
    check("R8 reset irq", {31'b0, irq_o}, 32'b0);
    rd_reg(7'h00); rd_reg(7'h20); rd_reg(7'h40); idle(1);
    // R2: unused bit 16 and core field placement
    step(0, 0, 0, 0, 32'hFFFF_FFFF, 9'h1FF); rd_reg(7'h20); rd_reg(7'h40);
    wr_reg(7'h20, 0); wr_reg(7'h40, 0); idle(1);
    // R4: event and clear on the same bit in one cycle
    wr_reg(7'h24, 32'h0000_0020);
    step(1, 1, 7'h28, 32'h0000_0020, 32'h0000_0020, 0); rd_reg(7'h20);
    step(1, 1, 7'h48, 32'h0100_0000, 0, 9'h100); rd_reg(7'h40);
    // R5, R6 masks and masked view
    wr_reg(7'h2C, 32'h0000_00F0); wr_reg(7'h30, 32'h8000_0000); wr_reg(7'h34, 32'h0000_0010);
    rd_reg(7'h2C); rd_reg(7'h38); wr_reg(7'h50, 32'h0100_0000); rd_reg(7'h58);
    // R7, R8: fire, ack, no re-fire until EOI
    idle(3); wr_reg(7'h28, 32'hFFFF_FFFF); wr_reg(7'h48, 32'hFFFF_FFFF); idle(2);
    wr_reg(7'h24, 32'h0000_0040); idle(4);
    wr_reg(7'h60, 32'h0); idle(4);
    wr_reg(7'h60, 32'hDEAD_BEEF); idle(3);
    wr_reg(7'h28, 32'hFFFF_FFFF); wr_reg(7'h48, 32'hFFFF_FFFF); idle(2); wr_reg(7'h60, 0); idle(2);
    // R9: soft reset clears everything, drops coincident events
    wr_reg(7'h24, 32'h1234_5678); wr_reg(7'h4C, 32'h01FF_0000);
    wr_reg(7'h04, 32'h1); step(1, 0, 7'h04, 0, 32'h0000_0003, 9'h003);
    rd_reg(7'h04); rd_reg(7'h20); rd_reg(7'h2C); rd_reg(7'h4C); rd_reg(7'h40);
    // R10 status, R11 reserved
    drvvbus_i = 1; rd_reg(7'h08); drvvbus_i = 0; rd_reg(7'h08);
    wr_reg(7'h10, 32'hFFFF_FFFF); wr_reg(7'h5C, 32'hFFFF_FFFF);
    rd_reg(7'h10); rd_reg(7'h5C); rd_reg(7'h7C); rd_reg(7'h24); rd_reg(7'h60);
    rd_reg(7'h2C); rd_reg(7'h20); idle(2);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, d, ep;
      logic [8:0] co;
      logic [6:0] a;
      r  = $urandom;
      a  = 7'(($urandom % 26) * 4);
      d  = $urandom;
      if (a == 7'h04 && ($urandom % 8) != 0) d[0] = 1'b0;
      ep = $urandom & $urandom & $urandom & $urandom;
      co = 9'($urandom & $urandom & $urandom);
      drvvbus_i = r[10];
      if (r[3:0] < 4'd5) step(1, 1, a, d, ep, co);
      else if (r[3:0] < 4'd10) step(1, 0, a, 0, ep, co);
      else step(0, 0, 0, 0, ep, co);
    end
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule